// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes a running CRC over data words offered on a write strobe. A 2-bit mode input picks one of four generator polynomials. A 2-bit length input makes each write carry one, two or four bytes. A new word is folded into the running value in the same clock cycle it is offered. The bytes of a word are consumed least significant byte first, and each byte is shifted in most significant bit first. Before data enters the polynomial division it can be bit-reversed inside each byte and inverted. The value on the checksum output can be reversed over the active CRC width and inverted. These options are independent control inputs.

A seed input gives the starting value. A one-cycle restart request, or the block reset, moves the controller into its reload state. It holds there for a fixed number of cycles while it copies the seed into the running value. Writes are dropped during that time. It then moves to the ready state, where writes are accepted only while the enable input is high.

The controller has two states. `ST_RELOAD` is entered from reset, and from `ST_READY` when a restart request arrives. A request seen while already in `ST_RELOAD` restarts the hold count. `ST_RELOAD` moves to `ST_READY` when the hold count is used up.

Top module: `crc_engine`

## Requirements
- R1: The mode input selects the polynomial: 0 selects 0x1021 (16-bit), 1 selects 0x07 (8-bit), 2 selects 0x8005 (16-bit) and 3 selects 0x04C11DB7 (32-bit). Each uses the non-reflected shift that takes the most significant bit first. With the seeds FFFF, 0, 0 and FFFFFFFF, the nine bytes "123456789" give 29B1, F4, FEE8 and 0376E6E7 in that order.
- R2: The length input sets how many bytes a write carries. Code 0 uses only data[7:0], code 1 uses only data[15:0], and codes 2 and 3 use all 32 bits. Unused data bits have no effect on the result.
- R3: An accepted write updates the state in the cycle it is strobed. A 32-bit write gives the same result as four 8-bit writes of its bytes, taken least significant byte first.
- R4: When the input-reverse control is set, the bit order inside each data byte is reversed and the byte positions are kept. With this control set, 0xAABBCCDD gives the same result as 0x55DD33BB written without it.
- R5: When the input-invert control is set, the data is one's complemented before it is folded into the CRC.
- R6: When the output-reverse control is set, the checksum is bit-reversed across the active CRC width. In 32-bit mode a state of 0xDD7B0F2E reads as 0x74F0DEBB, and in 8-bit mode a state of 0x01 reads as 0x80.
- R7: When the output-invert control is set, the checksum is one's complemented within the active CRC width.
- R8: A restart request makes the busy output high for exactly RST_CYCLES (default 3) cycles. During that time the seed, masked to the active width, is loaded and writes are ignored. After that time the checksum shows the seed.
- R9: While the enable input is low, writes do not change the checksum.
- R10: In 8-bit mode, checksum bits [31:8] read as zero. In the two 16-bit modes, checksum bits [31:16] read as zero.
- R11: After block reset the engine is busy. It then holds the seed, and the checksum shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_enable | input | 1 | Accept writes when high |
| cfg_mode | input | 2 | Polynomial select |
| cfg_len | input | 2 | Bytes per write: 0 = 1, 1 = 2, 2 or 3 = 4 |
| cfg_in_rev | input | 1 | Reverse bits within each input byte |
| cfg_in_inv | input | 1 | Invert input data |
| cfg_out_rev | input | 1 | Reverse checksum across the active width |
| cfg_out_inv | input | 1 | Invert checksum within the active width |
| seed | input | 32 | Initial CRC value |
| eng_rst_req | input | 1 | Restart request, seed reload |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 32 | Data word |
| reload_busy | output | 1 | High while in the reload state |
| checksum | output | 32 | Conditioned CRC result |

## Verification
The hardest state to reach from the ports is a write that lands while a restart is still being held. The bench reaches it by raising the restart request and keeping the write strobe high with a non-trivial word for the whole busy window. It drops the strobe on the same falling edge at which busy is first seen low, so no write reaches the edge that ends the hold. The checksum must then equal the seed. A second difficult case is checksum reversal on a state with a known value. The bench creates that state directly by loading it as a seed and reading it back with reversal enabled.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

    localparam int CRC_W = 32;

    typedef enum logic [1:0] {
        MODE_CCITT = 2'd0,
        MODE_CRC8  = 2'd1,
        MODE_CRC16 = 2'd2,
        MODE_CRC32 = 2'd3
    } crc_mode_e;

    typedef enum logic {
        ST_RELOAD = 1'b0,
        ST_READY  = 1'b1
    } eng_state_e;

    function automatic logic [5:0] mode_width(input crc_mode_e m);
        unique case (m)
            MODE_CRC8:  return 6'd8;
            MODE_CRC32: return 6'd32;
            default:    return 6'd16;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] mode_poly(input crc_mode_e m);
        unique case (m)
            MODE_CCITT: return 32'h0000_1021;
            MODE_CRC8:  return 32'h0000_0007;
            MODE_CRC16: return 32'h0000_8005;
            default:    return 32'h04C1_1DB7;
        endcase
    endfunction

endpackage

// File: rtl/crc_in_cond.sv
module crc_in_cond #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic              bit_rev,
    input  logic              invert,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] flipped;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign flipped[8*b+i] = din[8*b+7-i];
        end
    end

    assign dout = (bit_rev ? flipped : din) ^ {DATA_W{invert}};
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int CRC_W = 32
) (
    input  logic [CRC_W-1:0] acc_in,
    input  logic [7:0]       byte_in,
    input  logic [CRC_W-1:0] poly_al,
    output logic [CRC_W-1:0] acc_out
);
    // acc_in and poly_al are left-aligned to bit CRC_W-1
    logic [CRC_W-1:0] acc;

    always_comb begin
        acc = acc_in ^ {byte_in, {(CRC_W-8){1'b0}}};
        for (int i = 0; i < 8; i++) begin
            acc = acc[CRC_W-1] ? ((acc << 1) ^ poly_al) : (acc << 1);
        end
        acc_out = acc;
    end
endmodule

// File: rtl/crc_out_cond.sv
module crc_out_cond #(
    parameter int CRC_W = 32
) (
    input  logic [CRC_W-1:0] crc_val,
    input  logic [5:0]       shamt,
    input  logic [CRC_W-1:0] mask,
    input  logic             bit_rev,
    input  logic             invert,
    output logic [CRC_W-1:0] checksum_out
);
    logic [CRC_W-1:0] full_rev;
    logic [CRC_W-1:0] ordered;

    for (genvar i = 0; i < CRC_W; i++) begin : g_rev
        assign full_rev[i] = crc_val[CRC_W-1-i];
    end

    assign ordered      = bit_rev ? (full_rev >> shamt) : crc_val;
    assign checksum_out = (ordered ^ {CRC_W{invert}}) & mask;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_engine_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_in_rev,
    input  logic              cfg_in_inv,
    input  logic              cfg_out_rev,
    input  logic              cfg_out_inv,
    input  logic [CRC_W-1:0]  seed,
    input  logic              eng_rst_req,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              reload_busy,
    output logic [CRC_W-1:0]  checksum
);
    localparam int NBYTES = DATA_W / 8;
    localparam int HALF   = (NBYTES > 1) ? 2 : 1;
    localparam int CNT_W  = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RST_CYCLES - 1);

    eng_state_e         fsm_q, fsm_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CRC_W-1:0]   crc_q, crc_d;
    logic [5:0]         width, shamt;
    logic [CRC_W-1:0]   wmask, poly_al, picked, next_crc;
    logic [DATA_W-1:0]  cond_data;
    logic [NBYTES:0][CRC_W-1:0] stage;

    // ---- polynomial set-up ----
    always_comb begin
        width   = mode_width(crc_mode_e'(cfg_mode));
        shamt   = 6'(CRC_W) - width;
        wmask   = {CRC_W{1'b1}} >> shamt;
        poly_al = mode_poly(crc_mode_e'(cfg_mode)) << shamt;
    end

    crc_in_cond #(.DATA_W(DATA_W)) u_in (
        .din     (wr_data),
        .bit_rev (cfg_in_rev),
        .invert  (cfg_in_inv),
        .dout    (cond_data)
    );

    // ---- byte chain, least significant byte first ----
    assign stage[0] = crc_q << shamt;

    for (genvar b = 0; b < NBYTES; b++) begin : g_step
        crc_byte_step #(.CRC_W(CRC_W)) u_step (
            .acc_in  (stage[b]),
            .byte_in (cond_data[8*b +: 8]),
            .poly_al (poly_al),
            .acc_out (stage[b+1])
        );
    end

    always_comb begin
        unique case (cfg_len)
            2'd0:    picked = stage[1];
            2'd1:    picked = stage[HALF];
            default: picked = stage[NBYTES];
        endcase
        next_crc = picked >> shamt;
    end

    // ---- controller: next state ----
    always_comb begin
        fsm_d = fsm_q;
        cnt_d = cnt_q;
        unique case (fsm_q)
            ST_RELOAD: begin
                if (eng_rst_req)        cnt_d = HOLD_LOAD;
                else if (cnt_q == '0)   fsm_d = ST_READY;
                else                    cnt_d = cnt_q - 1'b1;
            end
            ST_READY: begin
                if (eng_rst_req) begin
                    fsm_d = ST_RELOAD;
                    cnt_d = HOLD_LOAD;
                end
            end
            default: fsm_d = ST_RELOAD;
        endcase
    end

    // ---- controller: state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= ST_RELOAD;
            cnt_q <= HOLD_LOAD;
        end else begin
            fsm_q <= fsm_d;
            cnt_q <= cnt_d;
        end
    end

    // ---- running CRC value ----
    always_comb begin
        if (fsm_q == ST_RELOAD || eng_rst_req)
            crc_d = seed & wmask;
        else if (wr_valid && cfg_enable)
            crc_d = next_crc;
        else
            crc_d = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    // ---- outputs ----
    assign reload_busy = (fsm_q == ST_RELOAD);

    crc_out_cond #(.CRC_W(CRC_W)) u_out (
        .crc_val      (crc_q),
        .shamt        (shamt),
        .mask         (wmask),
        .bit_rev      (cfg_out_rev),
        .invert       (cfg_out_inv),
        .checksum_out (checksum)
    );
endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker #(
    parameter int RST_CYCLES = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_enable,
    input logic [1:0]  cfg_mode,
    input logic        cfg_out_rev,
    input logic        cfg_out_inv,
    input logic        eng_rst_req,
    input logic        reload_busy,
    input logic [31:0] checksum
);
    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          busy_run <= '0;
        else if (!reload_busy || eng_rst_req) busy_run <= '0;
        else                                 busy_run <= busy_run + 8'd1;
    end

    a_r8_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst_req |=> reload_busy);

    a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        reload_busy |-> (int'(busy_run) < RST_CYCLES));

    a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !reload_busy && !eng_rst_req) |=>
        (!($stable(cfg_mode) && $stable(cfg_out_rev) && $stable(cfg_out_inv))
         || $stable(checksum)));

    a_r10_crc8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1) |-> (checksum[31:8] == 24'd0));

    a_r10_crc16_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 2'd3) |-> (checksum[31:16] == 16'd0));
endmodule

bind crc_engine crc_engine_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_mode    (cfg_mode),
    .cfg_out_rev (cfg_out_rev),
    .cfg_out_inv (cfg_out_inv),
    .eng_rst_req (eng_rst_req),
    .reload_busy (reload_busy),
    .checksum    (checksum)
);

// File: tb/crc_engine_bench.sv
`timescale 1ns/1ps
module crc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [1:0]  cfg_mode = 2'd3;
    logic [1:0]  cfg_len = 2'd2;
    logic        cfg_in_rev = 1'b0, cfg_in_inv = 1'b0;
    logic        cfg_out_rev = 1'b0, cfg_out_inv = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic        eng_rst_req = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        reload_busy;
    logic [31:0] checksum;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] model;
    logic [31:0] lcg = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    crc_engine u_crc_engine (.*);

    // mode, seed, expected result of "123456789"
    localparam logic [65:0] VEC [4] = '{
        {2'd3, 32'hFFFF_FFFF, 32'h0376_E6E7},
        {2'd0, 32'h0000_FFFF, 32'h0000_29B1},
        {2'd1, 32'h0000_0000, 32'h0000_00F4},
        {2'd2, 32'h0000_0000, 32'h0000_FEE8}
    };

    function automatic int f_w(input logic [1:0] m);
        return (m == 2'd1) ? 8 : (m == 2'd3) ? 32 : 16;
    endfunction

    function automatic logic [31:0] f_mask(input logic [1:0] m);
        return (m == 2'd1) ? 32'hFF : (m == 2'd3) ? 32'hFFFF_FFFF : 32'hFFFF;
    endfunction

    function automatic logic [31:0] f_poly(input logic [1:0] m);
        case (m)
            2'd0: return 32'h1021;
            2'd1: return 32'h07;
            2'd2: return 32'h8005;
            default: return 32'h04C1_1DB7;
        endcase
    endfunction

    function automatic logic [31:0] ref_feed(input logic [31:0] c, input logic [31:0] d,
            input logic [1:0] len, input logic [1:0] m, input logic irev, input logic iinv);
        int nb = (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 4;
        int w = f_w(m);
        logic [7:0] bt, r;
        logic fb;
        c = c & f_mask(m);
        for (int b = 0; b < nb; b++) begin
            bt = d[8*b +: 8];
            if (irev) begin
                for (int i = 0; i < 8; i++) r[i] = bt[7-i];
                bt = r;
            end
            if (iinv) bt = ~bt;
            for (int i = 7; i >= 0; i--) begin
                fb = c[w-1] ^ bt[i];
                c = (c << 1) & f_mask(m);
                if (fb) c = c ^ f_poly(m);
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_out(input logic [31:0] c, input logic [1:0] m,
            input logic orev, input logic oinv);
        int w = f_w(m);
        logic [31:0] r = c & f_mask(m);
        logic [31:0] t = '0;
        if (orev) begin
            for (int i = 0; i < w; i++) t[i] = r[w-1-i];
            r = t;
        end
        if (oinv) r = ~r & f_mask(m);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reload();
        @(negedge clk) eng_rst_req = 1'b1;
        @(negedge clk) eng_rst_req = 1'b0;
        while (reload_busy) @(negedge clk);
        model = seed & f_mask(cfg_mode);
    endtask

    task automatic wr(input logic [31:0] d, input logic [1:0] len);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; cfg_len = len;
        @(negedge clk);
        wr_valid = 1'b0;
        if (cfg_enable)
            model = ref_feed(model, d, len, cfg_mode, cfg_in_rev, cfg_in_inv);
    endtask

    function automatic logic [31:0] expect_now();
        return ref_out(model, cfg_mode, cfg_out_rev, cfg_out_inv);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    logic [31:0] c1;
    int n;

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 busy in reset", {31'd0, reload_busy}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", {31'd0, reload_busy}, 32'd1);
        while (reload_busy) @(negedge clk);
        chk("R11 seed after reset", checksum, 32'h1234_5678);

        // R1: polynomial table
        for (int v = 0; v < 4; v++) begin
            cfg_mode = VEC[v][65:64];
            seed     = VEC[v][63:32];
            reload();
            for (int k = 0; k < 9; k++) wr(32'h31 + k, 2'd0);
            chk($sformatf("R1 check value mode %0d", cfg_mode), checksum, VEC[v][31:0]);
        end

        // R8: busy window length
        cfg_mode = 2'd3; seed = 32'hAAAA_5555;
        @(negedge clk) eng_rst_req = 1'b1;
        @(negedge clk) eng_rst_req = 1'b0;
        n = 0;
        while (reload_busy && n < 20) begin n++; @(negedge clk); end
        chk("R8 busy cycles", n, 3);

        // R8: writes during reload are dropped
        @(negedge clk) eng_rst_req = 1'b1;
        @(negedge clk) begin eng_rst_req = 1'b0; wr_valid = 1'b1; wr_data = 32'hFFFF_FFFF; cfg_len = 2'd2; end
        while (reload_busy) @(negedge clk);
        wr_valid = 1'b0;
        chk("R8 write ignored while busy", checksum, 32'hAAAA_5555);

        // R3: word vs four bytes
        seed = 32'hFFFF_FFFF; reload();
        wr(32'h1234_5678, 2'd2);
        chk("R3 word write", checksum, expect_now());
        c1 = checksum;
        reload();
        wr(32'h78, 2'd0); wr(32'h56, 2'd0); wr(32'h34, 2'd0); wr(32'h12, 2'd0);
        chk("R3 byte order", checksum, c1);

        // R2: unused data bits
        cfg_mode = 2'd0; seed = 32'hFFFF; reload();
        wr(32'hDEAD_BE42, 2'd0);
        chk("R2 len8", checksum, ref_out(ref_feed(32'hFFFF, 32'h42, 2'd0, 2'd0, 0, 0), 2'd0, 0, 0));
        cfg_mode = 2'd2; seed = 32'h0; reload();
        wr(32'hCAFE_1234, 2'd1);
        chk("R2 len16", checksum, ref_out(ref_feed(32'h0, 32'h1234, 2'd1, 2'd2, 0, 0), 2'd2, 0, 0));
        cfg_mode = 2'd1; reload();
        wr(32'h0102_0304, 2'd3);
        chk("R2 len code 3", checksum, expect_now());

        // R4: per-byte input reversal
        cfg_mode = 2'd3; seed = 32'h0; reload();
        cfg_in_rev = 1'b1; wr(32'hAABB_CCDD, 2'd2); cfg_in_rev = 1'b0;
        chk("R4 reversed input", checksum, expect_now());
        c1 = checksum;
        reload(); wr(32'h55DD_33BB, 2'd2);
        chk("R4 equivalent word", checksum, c1);

        // R5: input complement
        seed = 32'h1357_9BDF; reload();
        cfg_in_inv = 1'b1; wr(32'h0F0F_3C3C, 2'd2); cfg_in_inv = 1'b0;
        chk("R5 inverted input", checksum, expect_now());
        c1 = checksum;
        reload(); wr(32'hF0F0_C3C3, 2'd2);
        chk("R5 equivalent word", checksum, c1);

        // R6: output reversal
        seed = 32'hDD7B_0F2E; reload(); cfg_out_rev = 1'b1;
        @(negedge clk);
        chk("R6 reverse 32", checksum, 32'h74F0_DEBB);
        cfg_mode = 2'd1; seed = 32'h01; reload();
        chk("R6 reverse 8", checksum, 32'h80);
        cfg_out_rev = 1'b0;

        // R7: output complement
        cfg_mode = 2'd2; seed = 32'h1234; reload(); cfg_out_inv = 1'b1;
        @(negedge clk);
        chk("R7 inverted output", checksum, 32'h0000_EDCB);
        cfg_out_inv = 1'b0;

        // R10: narrow widths
        cfg_mode = 2'd1; seed = 32'hFFFF_FFFF; reload();
        chk("R10 crc8 upper zero", checksum, 32'h0000_00FF);
        cfg_mode = 2'd0; reload();
        chk("R10 ccitt upper zero", checksum, 32'h0000_FFFF);

        // R9: disabled
        cfg_mode = 2'd3; seed = 32'h2468_ACE0; reload();
        cfg_enable = 1'b0;
        wr(32'h1111_2222, 2'd2); wr(32'h33, 2'd0);
        chk("R9 disabled holds", checksum, 32'h2468_ACE0);
        cfg_enable = 1'b1;

        // R1/R3: mixed stimulus against reference model
        for (int it = 0; it < 40; it++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            cfg_mode = lcg[31:30]; cfg_in_rev = lcg[29]; cfg_in_inv = lcg[28];
            cfg_out_rev = lcg[27]; cfg_out_inv = lcg[26];
            seed = lcg ^ 32'h5A5A_A5A5;
            reload();
            for (int k = 0; k < 5; k++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                wr(lcg ^ (lcg << 7), lcg[5:4]);
                chk($sformatf("R1 mixed it %0d", it), checksum, expect_now());
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule